// File: doc/BRIEF.md
# ALU Operand Forwarding Unit

This block sits beside the two ALU input multiplexers of the Compute stage in a five-stage in-order pipeline. For each ALU operand it decides where the value comes from. There are three choices: the value read from the register file during Decode, the ALU result of the previous cycle held in the Compute/Memory result register (RZ), or the value waiting in the Memory/Write register (RY) to be written back. The unit compares the source register numbers of the instruction in Compute with the destination register numbers of the two older instructions still in flight. It then drives a 2-bit select code for each input, together with the selected operand.

The priority is as follows. The younger producer in Memory wins over the older one in Write. A producer that does not write the register file, or that targets the hard-wired zero register, never forwards. A Load in the Memory stage holds only an address in RZ, so a match against it cannot select RZ. Loaded data is forwarded only later, from RY. An existing immediate select for operand B overrides forwarding on that input. The unit is purely combinational and has no clock. Stalling on hazards is handled elsewhere.

Top module: `alu_fwd_unit`

## Requirements
- R1: With no eligible match, the select for an input is 00 and that operand equals the register-file value. The code 11 is never produced.
- R2: When the instruction in Memory writes a non-zero destination equal to an input's source and is not a Load, the select is 01 and the operand equals the RZ value.
- R3: When only the instruction in Write matches (write enabled, non-zero destination equal to the source), the select is 10 and the operand equals the RY value.
- R4: When both older instructions match the same source, RZ is chosen (select 01).
- R5: A producer whose write enable is low is never forwarded from, whether it is in Memory or in Write.
- R6: A source of register 0 always gets select 00, even if a producer writes register 0.
- R7: A Load in Memory that matches a source never yields select 01. The select falls back to 10 if Write matches, and to 00 otherwise.
- R8: When the operand-B immediate flag is high, select B is 00 and operand B equals the immediate value. Operand A is unaffected.
- R9: The two inputs are resolved independently. They may take different sources in the same cycle, including the highest register number.
- R10: A non-writing instruction in Memory whose destination matches does not block forwarding from Write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cx_src_a | input | REG_AW | Source register for ALU input A, instruction in Compute |
| cx_src_b | input | REG_AW | Source register for ALU input B, instruction in Compute |
| cx_b_imm | input | 1 | Operand B takes the immediate |
| cx_imm | input | DATA_W | Immediate value for operand B |
| mx_dst | input | REG_AW | Destination register of instruction in Memory |
| mx_wr_en | input | 1 | Instruction in Memory writes the register file |
| mx_is_load | input | 1 | Instruction in Memory is a Load |
| wx_dst | input | REG_AW | Destination register of instruction in Write |
| wx_wr_en | input | 1 | Instruction in Write writes the register file |
| rf_a | input | DATA_W | Register-file value for input A |
| rf_b | input | DATA_W | Register-file value for input B |
| rz_val | input | DATA_W | Compute/Memory result register value |
| ry_val | input | DATA_W | Memory/Write value register |
| sel_a | output | 2 | Select code A: 00 file, 01 RZ, 10 RY |
| sel_b | output | 2 | Select code B: 00 file, 01 RZ, 10 RY |
| opnd_a | output | DATA_W | Selected ALU operand A |
| opnd_b | output | DATA_W | Selected ALU operand B |

## Verification
The block holds no state, so a wrong decision shows at the ports at once: in the same cycle its inputs change. A bad comparison or priority shows as a select code that points at the wrong stage. The operand then carries the RZ, RY or file value when a different one was expected. Each bench vector uses distinct data on the four data inputs and the immediate, so a wrong path is visible in the operand as well as in the code.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        FWD_RF = 2'b00,
        FWD_RZ = 2'b01,
        FWD_RY = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/fwd_select.sv
module fwd_select
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              mem_ok,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic              wb_ok,
    output fwd_sel_e          sel
);
    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = mem_ok && (src == mem_dst);
        wb_hit  = wb_ok  && (src == wb_dst);
        unique case ({mem_hit, wb_hit})
            2'b10, 2'b11: sel = FWD_RZ;   // newer producer wins
            2'b01:        sel = FWD_RY;
            default:      sel = FWD_RF;
        endcase
    end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] rz_val,
    input  logic [DATA_W-1:0] ry_val,
    input  logic [DATA_W-1:0] imm_val,
    output logic [DATA_W-1:0] opnd
);
    always_comb begin
        if (use_imm) begin
            opnd = imm_val;
        end else begin
            unique case (sel)
                FWD_RZ:  opnd = rz_val;
                FWD_RY:  opnd = ry_val;
                default: opnd = rf_val;
            endcase
        end
    end
endmodule

// File: rtl/alu_fwd_unit.sv
module alu_fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_AW    = 5,
    parameter int DATA_W    = 32,
    parameter bit ZERO_HARD = 1'b1
) (
    input  logic [REG_AW-1:0] cx_src_a,
    input  logic [REG_AW-1:0] cx_src_b,
    input  logic              cx_b_imm,
    input  logic [DATA_W-1:0] cx_imm,
    input  logic [REG_AW-1:0] mx_dst,
    input  logic              mx_wr_en,
    input  logic              mx_is_load,
    input  logic [REG_AW-1:0] wx_dst,
    input  logic              wx_wr_en,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic [DATA_W-1:0] rz_val,
    input  logic [DATA_W-1:0] ry_val,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int NUM_OPND = 2;

    logic mx_dst_live;
    logic wx_dst_live;
    logic mx_ok;
    logic wx_ok;

    generate
        if (ZERO_HARD) begin : g_zero
            assign mx_dst_live = (mx_dst != '0);
            assign wx_dst_live = (wx_dst != '0);
        end else begin : g_nozero
            assign mx_dst_live = 1'b1;
            assign wx_dst_live = 1'b1;
        end
    endgenerate

    // RZ holds an address, not data, while a Load sits in Memory
    assign mx_ok = mx_wr_en && mx_dst_live && !mx_is_load;
    assign wx_ok = wx_wr_en && wx_dst_live;

    logic [REG_AW-1:0] src_v [NUM_OPND];
    logic              imm_v [NUM_OPND];
    logic [DATA_W-1:0] rf_v  [NUM_OPND];
    fwd_sel_e          raw_sel [NUM_OPND];
    logic [DATA_W-1:0] op_v  [NUM_OPND];

    assign src_v[0] = cx_src_a;
    assign src_v[1] = cx_src_b;
    assign imm_v[0] = 1'b0;
    assign imm_v[1] = cx_b_imm;
    assign rf_v[0]  = rf_a;
    assign rf_v[1]  = rf_b;

    generate
        for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
            fwd_select #(.REG_AW(REG_AW)) u_sel (
                .src     (src_v[i]),
                .mem_dst (mx_dst),
                .mem_ok  (mx_ok),
                .wb_dst  (wx_dst),
                .wb_ok   (wx_ok),
                .sel     (raw_sel[i])
            );
            fwd_operand_mux #(.DATA_W(DATA_W)) u_mux (
                .sel     (raw_sel[i]),
                .use_imm (imm_v[i]),
                .rf_val  (rf_v[i]),
                .rz_val  (rz_val),
                .ry_val  (ry_val),
                .imm_val (cx_imm),
                .opnd    (op_v[i])
            );
        end
    endgenerate

    assign sel_a  = raw_sel[0];
    assign sel_b  = cx_b_imm ? FWD_RF : raw_sel[1];
    assign opnd_a = op_v[0];
    assign opnd_b = op_v[1];

    // Checks against the port-level rules
    always_comb begin
        if (!$isunknown({cx_src_a, cx_src_b, cx_b_imm, mx_dst, mx_wr_en,
                         mx_is_load, wx_dst, wx_wr_en})) begin
            p_sel_legal_r1: assert (sel_a != 2'b11 && sel_b != 2'b11);
            p_rz_source_r2: assert (sel_a != FWD_RZ ||
                (mx_wr_en && !mx_is_load && mx_dst == cx_src_a));
            p_ry_source_r3: assert (sel_a != FWD_RY ||
                (wx_wr_en && wx_dst == cx_src_a));
            p_rz_priority_r4: assert (!(mx_wr_en && !mx_is_load &&
                mx_dst == cx_src_a && cx_src_a != '0) || sel_a == FWD_RZ);
            p_zero_reg_r6: assert (!ZERO_HARD || cx_src_a != '0 ||
                sel_a == FWD_RF);
            p_no_rz_load_r7: assert (!mx_is_load ||
                (sel_a != FWD_RZ && sel_b != FWD_RZ));
            p_imm_override_r8: assert (!cx_b_imm || sel_b == FWD_RF);
        end
    end
endmodule

// File: tb/test_alu_fwd_unit.sv
`timescale 1ns/1ps
module test_alu_fwd_unit;
    localparam int AW = 5;
    localparam int DW = 32;
    localparam logic [DW-1:0] V_RFA = 32'h1111_1111;
    localparam logic [DW-1:0] V_RFB = 32'h2222_2222;
    localparam logic [DW-1:0] V_RZ  = 32'h3333_3333;
    localparam logic [DW-1:0] V_RY  = 32'h4444_4444;
    localparam logic [DW-1:0] V_IMM = 32'h5555_5555;

    typedef struct {
        logic [1:0]    sa;
        logic [1:0]    sb;
        logic [DW-1:0] oa;
        logic [DW-1:0] ob;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int checks = 0;
    int errors = 0;
    exp_t q[$];
    bit done = 1'b0;

    logic [AW-1:0] src_a = '0, src_b = '0, mdst = '0, wdst = '0;
    logic bimm = 1'b0, mwe = 1'b0, mld = 1'b0, wwe = 1'b0;
    logic [1:0] sel_a, sel_b;
    logic [DW-1:0] opnd_a, opnd_b;

    always #2.5 clk = ~clk;

    alu_fwd_unit i_alu_fwd_unit (
        .cx_src_a(src_a), .cx_src_b(src_b), .cx_b_imm(bimm), .cx_imm(V_IMM),
        .mx_dst(mdst), .mx_wr_en(mwe), .mx_is_load(mld),
        .wx_dst(wdst), .wx_wr_en(wwe),
        .rf_a(V_RFA), .rf_b(V_RFB), .rz_val(V_RZ), .ry_val(V_RY),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    function automatic logic [DW-1:0] pick(logic [1:0] s, logic [DW-1:0] rf);
        case (s)
            2'b01:   return V_RZ;
            2'b10:   return V_RY;
            default: return rf;
        endcase
    endfunction

    task automatic drive(input logic [AW-1:0] sa, input logic [AW-1:0] sb,
                         input logic bi, input logic [AW-1:0] md,
                         input logic me, input logic ml,
                         input logic [AW-1:0] wd, input logic we,
                         input logic [1:0] esa, input logic [1:0] esb,
                         input string tag);
        exp_t e;
        @(posedge clk);
        src_a = sa; src_b = sb; bimm = bi; mdst = md; mwe = me; mld = ml;
        wdst = wd; wwe = we;
        e.sa = esa; e.sb = esb;
        e.oa = pick(esa, V_RFA);
        e.ob = bi ? V_IMM : pick(esb, V_RFB);
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compare at the falling edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (sel_a !== e.sa || sel_b !== e.sb ||
                opnd_a !== e.oa || opnd_b !== e.ob) begin
                errors++;
                $display("FAIL %s: sel_a=%b sel_b=%b a=%h b=%h expected sel_a=%b sel_b=%b a=%h b=%h",
                         e.tag, sel_a, sel_b, opnd_a, opnd_b,
                         e.sa, e.sb, e.oa, e.ob);
            end
        end
    end

    initial begin
        // R1 reset state: idle inputs
        drive(0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, "R1 reset");
        rst_n = 1'b1;
        drive(3, 4, 0, 5, 1, 0, 6, 1, 2'b00, 2'b00, "R1 no match");
        drive(2, 4, 0, 2, 1, 0, 6, 1, 2'b01, 2'b00, "R2 RZ to A");
        drive(3, 7, 0, 7, 1, 0, 6, 1, 2'b00, 2'b01, "R2 RZ to B");
        drive(9, 4, 0, 5, 1, 0, 9, 1, 2'b10, 2'b00, "R3 RY to A");
        drive(2, 2, 0, 2, 1, 0, 2, 1, 2'b01, 2'b01, "R4 RZ priority");
        drive(2, 3, 0, 2, 0, 0, 2, 1, 2'b10, 2'b00, "R10 idle Memory");
        drive(9, 9, 0, 1, 1, 0, 9, 0, 2'b00, 2'b00, "R5 Write disabled");
        drive(0, 0, 0, 0, 1, 0, 0, 1, 2'b00, 2'b00, "R6 zero reg");
        drive(2, 3, 0, 2, 1, 1, 6, 1, 2'b00, 2'b00, "R7 load no RY");
        drive(2, 2, 0, 2, 1, 1, 2, 1, 2'b10, 2'b10, "R7 load via RY");
        drive(7, 7, 1, 7, 1, 0, 7, 1, 2'b01, 2'b00, "R8 immediate");
        drive(3, 4, 0, 3, 1, 0, 4, 1, 2'b01, 2'b10, "R9 split sources");
        drive(31, 31, 0, 30, 1, 0, 31, 1, 2'b10, 2'b10, "R9 top register");
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule